// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter with Clear-to-Send Pacing

This block sends characters on an asynchronous serial line. A character is written into a one-entry holding buffer. As soon as the shift register is free, the character moves there and goes out as a frame: a low start bit, then 8 or 9 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. Between frames the line rests high. A reload divider followed by a fixed oversampling counter sets the bit time.

Two flags tell software when it may act. `buf_empty` means the holding buffer can take a new character. `shift_empty` means the line is idle. An interrupt request can be tied to either event, and it stays set until it is acknowledged.

When flow control is on, a synchronized active-low clear-to-send input is checked each time the shifter is ready to take the next character. While that input is high, the bit clock stays stopped and the waiting character is held back. The start bit goes out as soon as the input is seen low again. Clearing the transmit enable also stops the bit clock: a frame already on the line freezes in place, and no new frame begins.

Top module: `sertx_top`

## Requirements
- R1: After reset `txd` is 1, `buf_empty` is 1, `shift_empty` is 1 and `irq` is 0.
- R2: Each bit lasts exactly 16 × (`div_val` + 1) clock cycles.
- R3: The frame bits in order are: a start bit of 0; the data bits from `wr_data[0]` upward (8 bits when `nine_bit`=0, 9 bits when `nine_bit`=1); a parity bit only when `nine_bit`=0 and `par_en`=1 (`par_en` has no effect when `nine_bit`=1); then one stop bit of 1, or two when `two_stop`=1.
- R4: When `par_odd`=0 the parity bit is the XOR of the 8 data bits (even parity). When `par_odd`=1 it is the inverse of that XOR (odd parity).
- R5: `buf_empty` falls on the clock edge that takes in a write. While the shifter is idle, the character moves to the shifter on the next edge. On that edge `buf_empty` rises and `txd` goes to 0 for the start bit. `buf_empty` never rises without such a move.
- R6: `shift_empty` is 0 from the move until the last stop bit ends. It then returns to 1 with `txd` high, unless a waiting character is moved on that same edge. In that case the next start bit follows the last stop bit with no gap.
- R7: When `irq_sel`=0, `irq` is set on the edge where a character moves from the buffer to the shifter.
- R8: When `irq_sel`=1, `irq` is set only on the edge where a frame ends and no next frame starts. A frame followed at once by another sets nothing.
- R9: Once set, `irq` stays 1 until a cycle with `irq_ack`=1 clears it on the next edge. A new set in the same cycle wins over the acknowledge.
- R10: When `cts_en`=1 and the synchronized `cts_n` is 1 at the moment the shifter could take a character, no frame starts. `txd` stays 1, `shift_empty` is 1 and `buf_empty` stays 0.
- R11: `cts_n` passes through a two-stage synchronizer. If it falls before edge A, the held start bit goes out on the second edge after A.
- R12: When `cts_en`=0, `cts_n` has no effect on when a frame starts.
- R13: While `tx_en`=0 no frame starts. A frame already on the line stops changing, and it continues once `tx_en` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the count source for the bit timer |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable; 0 stops the bit clock and blocks new frames |
| div_val | input | DIV_W | Divider value n; bit time is 16(n+1) cycles |
| nine_bit | input | 1 | 1 selects 9 data bits with no parity |
| par_en | input | 1 | Parity bit enable in 8-bit mode |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| two_stop | input | 1 | 1 selects two stop bits |
| cts_en | input | 1 | Enables clear-to-send pacing |
| cts_n | input | 1 | Active-low clear-to-send, asynchronous |
| irq_sel | input | 1 | Interrupt source: 0 buffer empty, 1 transmission complete |
| irq_ack | input | 1 | Clears the interrupt request |
| wr_stb | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 9 | Character to send; bit 8 used only in 9-bit mode |
| txd | output | 1 | Serial output, idles high |
| buf_empty | output | 1 | Holding buffer can accept a character |
| shift_empty | output | 1 | No frame on the line |
| irq | output | 1 | Sticky interrupt request |

## Verification
The first edge where internal state goes wrong shows up at the ports within one bit time. A shift register or bit counter that is off by one gives a wrong sampled bit, or a frame that is one bit too long or too short. The check of `shift_empty` on the edge right after the expected last stop bit catches this. A wrong buffer-full state shows on `buf_empty` one edge after a write or a move. A flow-control gate that lets a frame through shows as a falling `txd` while clear-to-send is high. The release timing is checked to the exact edge, two edges after the synchronizer takes in the low level.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  // Longest frame: start + 9 data + 2 stop, or start + 8 data + parity + 2 stop
  localparam int FRAME_MAX = 12;
  localparam int LEN_W     = $clog2(FRAME_MAX + 1);

  typedef logic [FRAME_MAX-1:0] frame_t;
  typedef logic [LEN_W-1:0]     flen_t;

  // Parity over the 8 low data bits; odd flips the even result
  function automatic logic calc_parity(input logic [8:0] data, input logic odd);
    return (^data[7:0]) ^ odd;
  endfunction

  // Number of bit slots in a frame for the given configuration
  function automatic flen_t calc_len(input logic nine, input logic par_en,
                                     input logic two_stop);
    int n;
    n = 9;                                  // start + 8 data
    if (nine) n = n + 1;                    // ninth data bit
    else if (par_en) n = n + 1;             // parity slot
    n = n + (two_stop ? 2 : 1);             // stop slots
    return flen_t'(n);
  endfunction

  // Frame image, bit 0 leaves first; unused high slots read as stop level
  function automatic frame_t calc_frame(input logic [8:0] data, input logic nine,
                                        input logic par_en, input logic odd);
    frame_t f;
    f      = '1;
    f[0]   = 1'b0;
    f[8:1] = data[7:0];
    if (nine)        f[9] = data[8];
    else if (par_en) f[9] = calc_parity(data, odd);
    return f;
  endfunction

endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
  parameter int DIV_W = 8,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_val,
  output logic             bit_tick
);
  localparam int SUB_W = (OVS > 2) ? $clog2(OVS) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

  logic [DIV_W-1:0] pre_q;
  logic [SUB_W-1:0] sub_q;
  logic             pre_end;
  logic             sub_end;

  assign pre_end  = (pre_q >= div_val);
  assign sub_end  = (sub_q == SUB_LAST);
  assign bit_tick = run && pre_end && sub_end;

  // Both stages restart from zero whenever the clock is not running,
  // so the first bit after a start always gets a full period.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      sub_q <= '0;
    end else if (!run) begin
      pre_q <= '0;
      sub_q <= '0;
    end else if (pre_end) begin
      pre_q <= '0;
      sub_q <= sub_end ? '0 : sub_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

endmodule

// File: rtl/sertx_sync.sv
module sertx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= {stg_q[STAGES-2:0], d};
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  frame_t load_frame,
  input  flen_t  load_len,
  input  logic   bit_tick,
  output logic   busy,
  output logic   frame_end,
  output logic   txd
);
  frame_t sh_q;
  flen_t  len_q;
  flen_t  cnt_q;
  logic   busy_q;

  assign frame_end = busy_q && bit_tick && (cnt_q == len_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      len_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (load) begin
      sh_q   <= load_frame;
      len_q  <= load_len;
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (frame_end) begin
      sh_q   <= '1;
      busy_q <= 1'b0;
    end else if (busy_q && bit_tick) begin
      sh_q   <= {1'b1, sh_q[FRAME_MAX-1:1]};
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign busy = busy_q;
  assign txd  = busy_q ? sh_q[0] : 1'b1;

endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int OVS   = 16,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic [DIV_W-1:0] div_val,
  input  logic             nine_bit,
  input  logic             par_en,
  input  logic             par_odd,
  input  logic             two_stop,
  input  logic             cts_en,
  input  logic             cts_n,
  input  logic             irq_sel,
  input  logic             irq_ack,
  input  logic             wr_stb,
  input  logic [8:0]       wr_data,
  output logic             txd,
  output logic             buf_empty,
  output logic             shift_empty,
  output logic             irq
);
  // Holding buffer
  logic [8:0] buf_data_q;
  logic       buf_full_q;

  // Named internal events
  logic cts_s;        // synchronized clear-to-send, active low
  logic cts_ok;       // pacing allows a new frame
  logic busy;         // a frame is on the line
  logic frame_end;    // last stop bit finishing this cycle
  logic shifter_free; // shifter may take a character this cycle
  logic ev_load;      // buffer -> shifter move
  logic ev_done;      // frame ended with no follow-on
  logic ev_irq;       // selected interrupt source
  logic run;          // bit clock running
  logic bit_tick;     // one bit period elapsed
  logic irq_q;

  sertx_sync #(.STAGES(SYNC), .RST_VAL(1'b1)) i_cts_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (cts_n),
    .q     (cts_s)
  );

  assign cts_ok       = !cts_en || !cts_s;
  assign shifter_free = !busy || frame_end;
  assign ev_load      = buf_full_q && tx_en && cts_ok && shifter_free;
  assign ev_done      = frame_end && !ev_load;
  assign run          = tx_en && busy;
  assign ev_irq       = irq_sel ? ev_done : ev_load;

  sertx_baud #(.DIV_W(DIV_W), .OVS(OVS)) i_baud (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .div_val  (div_val),
    .bit_tick (bit_tick)
  );

  sertx_shift i_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (ev_load),
    .load_frame (calc_frame(buf_data_q, nine_bit, par_en, par_odd)),
    .load_len   (calc_len(nine_bit, par_en, two_stop)),
    .bit_tick   (bit_tick),
    .busy       (busy),
    .frame_end  (frame_end),
    .txd        (txd)
  );

  // A write in the same cycle as a move refills the buffer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_data_q <= '0;
      buf_full_q <= 1'b0;
    end else if (wr_stb) begin
      buf_data_q <= wr_data;
      buf_full_q <= 1'b1;
    end else if (ev_load) begin
      buf_full_q <= 1'b0;
    end
  end

  // Sticky request; a new event outranks the acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_q <= 1'b0;
    else if (ev_irq)  irq_q <= 1'b1;
    else if (irq_ack) irq_q <= 1'b0;
  end

  assign buf_empty   = !buf_full_q;
  assign shift_empty = !busy;
  assign irq         = irq_q;

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic irq_ack,
  input logic txd,
  input logic buf_empty,
  input logic shift_empty,
  input logic irq,
  input logic ev_load,
  input logic ev_done,
  input logic bit_tick,
  input logic cts_ok
);

  // R5
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!buf_empty && !ev_load) |=> !buf_empty);

  // R6
  load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load |=> !shift_empty);

  // R6
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_empty |-> txd);

  // R6
  done_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shift_empty) |-> $past(ev_done));

  // R13
  halt_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !bit_tick);

  // R10
  cts_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load |-> cts_ok);

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq);

endmodule

bind sertx_top sertx_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tx_en       (tx_en),
  .irq_ack     (irq_ack),
  .txd         (txd),
  .buf_empty   (buf_empty),
  .shift_empty (shift_empty),
  .irq         (irq),
  .ev_load     (ev_load),
  .ev_done     (ev_done),
  .bit_tick    (bit_tick),
  .cts_ok      (cts_ok)
);

// File: tb/test_sertx_top.sv
module test_sertx_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 150000;

  typedef struct packed {
    logic [8:0] d;
    logic       nine;
    logic       pe;
    logic       po;
    logic       ts;
    logic [7:0] dv;
  } vec_t;

  // Every entry has data bit 0 = 1 so the start-bit width is measurable
  localparam int NVEC = 5;
  localparam vec_t VECS [NVEC] = '{
    '{9'h0A5, 1'b0, 1'b1, 1'b0, 1'b0, 8'd0},
    '{9'h037, 1'b0, 1'b1, 1'b1, 1'b1, 8'd1},
    '{9'h001, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0},
    '{9'h1C3, 1'b1, 1'b1, 1'b0, 1'b1, 8'd0},
    '{9'h0FF, 1'b1, 1'b0, 1'b1, 1'b0, 8'd2}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b1;
  logic [7:0] div_val = 8'd0;
  logic       nine_bit = 1'b0, par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0;
  logic       cts_en = 1'b0, cts_n = 1'b0, irq_sel = 1'b0, irq_ack = 1'b0;
  logic       wr_stb = 1'b0;
  logic [8:0] wr_data = '0;
  logic       txd, buf_empty, shift_empty, irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  sertx_top i_sertx_top (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .div_val(div_val),
    .nine_bit(nine_bit), .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
    .cts_en(cts_en), .cts_n(cts_n), .irq_sel(irq_sel), .irq_ack(irq_ack),
    .wr_stb(wr_stb), .wr_data(wr_data),
    .txd(txd), .buf_empty(buf_empty), .shift_empty(shift_empty), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WDOG_LIMIT) begin
      errors = errors + 1;
      $display("FAIL watchdog: got %0d cycles expected below %0d", cyc, WDOG_LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected frame built slot by slot from the requirements
  task automatic expect_frame(input logic [8:0] d, input logic nine, input logic pe,
                              input logic po, input logic ts,
                              output int len, output logic [11:0] bits);
    int idx;
    int ones;
    bits = '0;
    idx = 0;
    bits[idx] = 1'b0; idx++;
    for (int k = 0; k < (nine ? 9 : 8); k++) begin
      bits[idx] = d[k]; idx++;
    end
    if (!nine && pe) begin
      ones = 0;
      for (int k = 0; k < 8; k++) ones += int'(d[k]);
      bits[idx] = logic'(ones % 2) ^ po; idx++;
    end
    bits[idx] = 1'b1; idx++;
    if (ts) begin bits[idx] = 1'b1; idx++; end
    len = idx;
  endtask

  task automatic write_char(input logic [8:0] d);
    wr_data = d;
    wr_stb  = 1'b1;
    @(negedge clk);
    wr_stb  = 1'b0;
  endtask

  // Sample a frame at mid-bit; slot 0 is the current negedge unless wait_start
  task automatic capture(input int len, input int bl, input bit wait_start,
                         output logic [11:0] bits, output int low_run);
    bit run_open;
    if (wait_start) begin
      for (int w = 0; w < 4000; w++) begin
        @(negedge clk);
        if (txd == 1'b0) break;
      end
    end
    bits = '0;
    low_run = 0;
    run_open = 1'b1;
    for (int i = 0; i < len * bl; i++) begin
      if (i > 0) @(negedge clk);
      if (run_open && txd == 1'b0) low_run++;
      else run_open = 1'b0;
      if (i % bl == bl / 2) bits[i / bl] = txd;
    end
  endtask

  task automatic do_ack();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  initial begin
    int          len, lr, bl;
    logic [11:0] eb, gb;
    int          bad;

    repeat (3) @(negedge clk);
    // R1 reset values
    check(txd === 1'b1, "R1", "txd in reset", int'(txd), 1);
    check(buf_empty === 1'b1, "R1", "buf_empty in reset", int'(buf_empty), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(shift_empty === 1'b1, "R1", "shift_empty after reset", int'(shift_empty), 1);
    check(irq === 1'b0, "R1", "irq after reset", int'(irq), 0);

    // Table walk: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < NVEC; v++) begin
      nine_bit = VECS[v].nine; par_en = VECS[v].pe; par_odd = VECS[v].po;
      two_stop = VECS[v].ts;   div_val = VECS[v].dv; irq_sel = 1'b0;
      bl = 16 * (int'(VECS[v].dv) + 1);
      expect_frame(VECS[v].d, VECS[v].nine, VECS[v].pe, VECS[v].po, VECS[v].ts, len, eb);
      write_char(VECS[v].d);
      check(buf_empty === 1'b0 && txd === 1'b1, "R5", "buffer full before move",
            int'(buf_empty), 0);
      @(negedge clk);
      check(buf_empty === 1'b1 && txd === 1'b0, "R5", "move and start bit edge",
            int'({buf_empty, txd}), 2);
      check(irq === 1'b1, "R7", "irq on move", int'(irq), 1);
      capture(len, bl, 1'b0, gb, lr);
      check(gb === eb, "R3", "frame bits", int'(gb), int'(eb));
      check(lr == bl, "R2", "start bit width", lr, bl);
      @(negedge clk);
      check(shift_empty === 1'b1 && txd === 1'b1, "R6", "idle after last stop",
            int'({shift_empty, txd}), 3);
      do_ack();
      check(irq === 1'b0, "R9", "irq cleared by ack", int'(irq), 0);
    end

    // R4 odd/even on the same data byte
    nine_bit = 1'b0; par_en = 1'b1; two_stop = 1'b0; div_val = 8'd0;
    for (int p = 0; p < 2; p++) begin
      par_odd = logic'(p);
      expect_frame(9'h0B1, 1'b0, 1'b1, logic'(p), 1'b0, len, eb);
      write_char(9'h0B1);
      capture(len, 16, 1'b1, gb, lr);
      check(gb[9] === eb[9], "R4", "parity bit", int'(gb[9]), int'(eb[9]));
      @(negedge clk);
    end
    par_odd = 1'b0;

    // R8 R9: completion interrupt, sticky until ack
    irq_sel = 1'b1;
    do_ack();
    expect_frame(9'h055, 1'b0, 1'b1, 1'b0, 1'b0, len, eb);
    write_char(9'h055);
    @(negedge clk);
    check(irq === 1'b0, "R8", "no irq on move", int'(irq), 0);
    capture(len, 16, 1'b0, gb, lr);
    @(negedge clk);
    check(irq === 1'b1, "R8", "irq at completion", int'(irq), 1);
    repeat (20) @(negedge clk);
    check(irq === 1'b1, "R9", "irq held without ack", int'(irq), 1);
    do_ack();
    check(irq === 1'b0, "R9", "irq cleared", int'(irq), 0);

    // R6 R8: back-to-back frames
    write_char(9'h0C3);
    write_char(9'h03D);
    check(buf_empty === 1'b0 && txd === 1'b0, "R6", "second char waiting",
          int'({buf_empty, txd}), 0);
    capture(len, 16, 1'b0, gb, lr);
    @(negedge clk);
    check(txd === 1'b0 && shift_empty === 1'b0, "R6", "no gap between frames",
          int'({shift_empty, txd}), 0);
    check(irq === 1'b0, "R8", "no irq between chained frames", int'(irq), 0);
    expect_frame(9'h03D, 1'b0, 1'b1, 1'b0, 1'b0, len, eb);
    capture(len, 16, 1'b0, gb, lr);
    check(gb === eb, "R6", "chained frame bits", int'(gb), int'(eb));
    @(negedge clk);
    check(shift_empty === 1'b1 && irq === 1'b1, "R8", "irq after chain",
          int'({shift_empty, irq}), 3);
    do_ack();
    irq_sel = 1'b0;

    // R10 R11: held by clear-to-send, released on exact edge
    cts_en = 1'b1; cts_n = 1'b1;
    repeat (3) @(negedge clk);
    write_char(9'h0E7);
    bad = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) bad++;
    end
    check(bad == 0, "R10", "txd stays high while held", bad, 0);
    check(shift_empty === 1'b1 && buf_empty === 1'b0, "R10", "flags while held",
          int'({shift_empty, buf_empty}), 2);
    cts_n = 1'b0;
    @(negedge clk);
    check(txd === 1'b1, "R11", "no start after first sync edge", int'(txd), 1);
    @(negedge clk);
    check(txd === 1'b1, "R11", "no start after second sync edge", int'(txd), 1);
    @(negedge clk);
    check(txd === 1'b0 && buf_empty === 1'b1, "R11", "start on release edge",
          int'({txd, buf_empty}), 1);
    expect_frame(9'h0E7, 1'b0, 1'b1, 1'b0, 1'b0, len, eb);
    capture(len, 16, 1'b0, gb, lr);
    check(gb === eb, "R11", "released frame bits", int'(gb), int'(eb));
    @(negedge clk);

    // R10: clear-to-send raised mid-frame holds the waiting character
    write_char(9'h011);
    write_char(9'h0AB);
    cts_n = 1'b1;
    capture(len, 16, 1'b0, gb, lr);
    @(negedge clk);
    check(txd === 1'b1 && shift_empty === 1'b1 && buf_empty === 1'b0, "R10",
          "held at stop check", int'({txd, shift_empty, buf_empty}), 6);
    repeat (40) @(negedge clk);
    check(txd === 1'b1, "R10", "still held", int'(txd), 1);
    cts_n = 1'b0;
    expect_frame(9'h0AB, 1'b0, 1'b1, 1'b0, 1'b0, len, eb);
    capture(len, 16, 1'b1, gb, lr);
    check(gb === eb, "R10", "held frame after release", int'(gb), int'(eb));
    @(negedge clk);

    // R12: pacing disabled ignores clear-to-send
    cts_en = 1'b0; cts_n = 1'b1;
    repeat (3) @(negedge clk);
    write_char(9'h0F1);
    @(negedge clk);
    check(txd === 1'b0, "R12", "start with cts_n high and pacing off", int'(txd), 0);
    capture(len, 16, 1'b0, gb, lr);
    @(negedge clk);
    cts_n = 1'b0;

    // R13: enable low blocks start and freezes a frame
    tx_en = 1'b0;
    write_char(9'h0F1);
    bad = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) bad++;
    end
    check(bad == 0 && buf_empty === 1'b0, "R13", "no start while disabled", bad, 0);
    tx_en = 1'b1;
    @(negedge clk);
    check(txd === 1'b0, "R13", "start after enable", int'(txd), 0);
    repeat (5) @(negedge clk);
    tx_en = 1'b0;
    bad = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (txd !== 1'b0 || shift_empty !== 1'b0) bad++;
    end
    check(bad == 0, "R13", "frame frozen while disabled", bad, 0);
    tx_en = 1'b1;
    bad = 1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (shift_empty === 1'b1) begin bad = 0; break; end
    end
    check(bad == 0 && txd === 1'b1, "R13", "frame completes after re-enable", bad, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule